// File: doc/BRIEF.md
# Windowed-Configuration Priority Interrupt Router

This block collects a set of level-sensitive interrupt request lines. Each line belongs to one 2-byte vector slot, so the vector offset is twice the request index. For every request the block keeps a 3-bit priority level and a destination bit. The destination bit selects either the main CPU or a coprocessor. On every clock the block finds the strongest pending request for each destination and registers its vector offset and level on that destination's port.

Software reaches the per-vector settings through a small register file. One address register chooses a window of eight consecutive vectors. Eight data registers then read and write the configuration byte of each vector in that window. Some slots are fixed or missing:
- The spurious vector is fixed.
- Slots next to the spurious vector have no storage.
- Only the first two slots of the top window are kept.
- Channels marked unused behave as empty.
- The external IRQ slot cannot be sent to the coprocessor.

Top module: `wcfg_router`

## Requirements
- R1: After a synchronous reset, every vector that has storage holds level 1 with destination CPU, and the address register reads 0x00.
- R2: A level of 0 removes a request from arbitration. Among the pending requests routed to a port, the one with the numerically largest level (1..7) is presented.
- R3: When pending requests on one port share the top level, the one with the larger vector offset is presented.
- R4: Configuration byte bit 7 picks the destination: 0 sends the request to the CPU port, 1 sends it to the coprocessor port. Bits 2:0 hold the level.
- R5: The external IRQ vector (top window, slot 1) ignores writes to bit 7. Its bit 7 always reads 0, so its request always goes to the CPU.
- R6: Register select 8 is the address register. It keeps only bits OFS_W-1:4 of a write, reads them back with bits 3:0 as zero, and selects window = written offset / 16.
- R7: Register selects 0..7 reach vector window*8+select. Bits 6:3 of a configuration byte ignore writes and read 0.
- R8: In the top window, selects 2..7 ignore writes and read 0x00.
- R9: In the lowest configurable window (LO_WIN), select 0 is the spurious vector: it ignores writes, reads 0x07 and never requests. Selects 1..4 of that window ignore writes and read 0x00.
- R10: Vectors marked unused and every vector below window LO_WIN ignore writes, read 0x00 and never win arbitration.
- R11: Each port has a valid output that is high only when a routed, enabled request is pending. With nothing pending, the CPU port shows the spurious offset (LO_WIN*16) at level 0 and the coprocessor port shows offset 0 at level 0.
- R12: Port outputs follow the request and configuration state one clock after it is sampled. Read data updates one clock after a read strobe and holds when there is no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 2**(OFS_W-1) | Level request per vector slot |
| reg_sel | input | 4 | Register select: 0..7 window data, 8 address |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_valid | output | 1 | CPU port has a pending request |
| cpu_vec | output | OFS_W | CPU port vector offset |
| cpu_lvl | output | 3 | CPU port priority level |
| cop_valid | output | 1 | Coprocessor port has a pending request |
| cop_vec | output | OFS_W | Coprocessor port vector offset |
| cop_lvl | output | 3 | Coprocessor port priority level |

## Verification
The bench builds the router with OFS_W=6 and LO_WIN=1, and clears USED_MASK bit 20. That gives 32 vectors in four windows: window 0 below the configurable range, the spurious and missing slots in window 1, an unused channel inside the ordinary window 2, and the two-entry top window 3 holding the IRQ slot. Every special case therefore sits within a few register writes of reset. Level ties, destination splits and the spurious idle offset can all be driven from a 32-bit request word.

// File: rtl/wcfg_pkg.sv
package wcfg_pkg;

  typedef struct packed {
    logic       route;
    logic [2:0] lvl;
  } vcfg_t;

  localparam logic [3:0] SEL_ADDR = 4'd8;

  // true when vector v owns writable configuration storage
  function automatic bit has_cfg(int v, int lo_win, int top_win, bit used);
    int w;
    int s;
    w = v / 8;
    s = v % 8;
    if (!used) return 1'b0;
    if (w < lo_win) return 1'b0;
    if (w == lo_win && s <= 4) return 1'b0;
    if (w == top_win && s >= 2) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/wcfg_store.sv
module wcfg_store
  import wcfg_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LO_WIN = 1,
  parameter logic [(1 << (OFS_W - 1)) - 1:0] USED_MASK = '1,
  localparam int NVEC = 1 << (OFS_W - 1),
  localparam int VEC_W = OFS_W - 1,
  localparam int WIN_W = OFS_W - 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            reg_sel,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  output logic [WIN_W-1:0]      cur_win,
  output vcfg_t [NVEC-1:0]      cfg
);

  localparam int TOP_WIN = (1 << WIN_W) - 1;
  localparam int IRQ_VEC = TOP_WIN * 8 + 1;
  localparam logic [VEC_W-1:0] SPUR_IDX = VEC_W'(LO_WIN * 8);

  logic [WIN_W-1:0] win_q;
  logic [VEC_W-1:0] sel_idx;
  logic [7:0]       rd_next;
  vcfg_t            rd_ent;

  assign cur_win = win_q;
  assign sel_idx = {win_q, reg_sel[2:0]};

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (reg_we && reg_sel == SEL_ADDR) win_q <= reg_wdata[OFS_W-1:4];
  end

  for (genvar v = 0; v < NVEC; v++) begin : g_ent
    localparam bit HAS = has_cfg(v, LO_WIN, TOP_WIN, USED_MASK[v]);
    if (HAS) begin : g_st
      vcfg_t ent_q;
      logic  wr_hit;
      assign wr_hit = reg_we && !reg_sel[3] && (sel_idx == VEC_W'(v));
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_q.route <= 1'b0;
          ent_q.lvl   <= 3'd1;
        end else if (wr_hit) begin
          ent_q.lvl   <= reg_wdata[2:0];
          ent_q.route <= (v == IRQ_VEC) ? 1'b0 : reg_wdata[7];
        end
      end
      assign cfg[v] = ent_q;
    end else begin : g_none
      assign cfg[v] = '0;
    end
  end

  always_comb begin
    rd_ent = cfg[sel_idx];
    if (reg_sel == SEL_ADDR)   rd_next = 8'({win_q, 4'b0000});
    else if (reg_sel[3])       rd_next = 8'h00;
    else if (sel_idx == SPUR_IDX) rd_next = 8'h07;
    else                       rd_next = {rd_ent.route, 4'b0000, rd_ent.lvl};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else if (reg_re) reg_rdata <= rd_next;
  end

endmodule

// File: rtl/wcfg_arb.sv
module wcfg_arb
  import wcfg_pkg::*;
#(
  parameter int NVEC = 128,
  parameter bit DEST = 1'b0,
  localparam int VEC_W = $clog2(NVEC)
) (
  input  logic [NVEC-1:0]   req,
  input  vcfg_t [NVEC-1:0]  cfg,
  output logic              hit,
  output logic [VEC_W-1:0]  idx,
  output logic [2:0]        lvl
);

  // ascending scan with >= lets the larger index win on equal level
  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = 3'd0;
    for (int v = 0; v < NVEC; v++) begin
      if (req[v] && cfg[v].route == DEST && cfg[v].lvl != 3'd0 && cfg[v].lvl >= lvl) begin
        hit = 1'b1;
        idx = VEC_W'(v);
        lvl = cfg[v].lvl;
      end
    end
  end

endmodule

// File: rtl/wcfg_router.sv
module wcfg_router
  import wcfg_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int LO_WIN = 1,
  parameter logic [(1 << (OFS_W - 1)) - 1:0] USED_MASK = '1,
  localparam int NVEC = 1 << (OFS_W - 1),
  localparam int VEC_W = OFS_W - 1,
  localparam int WIN_W = OFS_W - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NVEC-1:0]   irq_req,
  input  logic [3:0]        reg_sel,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cpu_valid,
  output logic [OFS_W-1:0]  cpu_vec,
  output logic [2:0]        cpu_lvl,
  output logic              cop_valid,
  output logic [OFS_W-1:0]  cop_vec,
  output logic [2:0]        cop_lvl
);

  localparam logic [OFS_W-1:0] SPUR_OFS = OFS_W'(LO_WIN * 16);

  vcfg_t [NVEC-1:0]  cfg;
  logic [WIN_W-1:0]  cur_win;
  logic              hit [2];
  logic [VEC_W-1:0]  idx [2];
  logic [2:0]        lvl [2];

  wcfg_store #(.OFS_W(OFS_W), .LO_WIN(LO_WIN), .USED_MASK(USED_MASK)) u_store (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_win(cur_win), .cfg(cfg)
  );

  for (genvar d = 0; d < 2; d++) begin : g_dest
    wcfg_arb #(.NVEC(NVEC), .DEST(d == 1)) u_arb (
      .req(irq_req), .cfg(cfg), .hit(hit[d]), .idx(idx[d]), .lvl(lvl[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_valid <= 1'b0;
      cpu_vec   <= SPUR_OFS;
      cpu_lvl   <= 3'd0;
      cop_valid <= 1'b0;
      cop_vec   <= '0;
      cop_lvl   <= 3'd0;
    end else begin
      cpu_valid <= hit[0];
      cpu_vec   <= hit[0] ? {idx[0], 1'b0} : SPUR_OFS;
      cpu_lvl   <= lvl[0];
      cop_valid <= hit[1];
      cop_vec   <= hit[1] ? {idx[1], 1'b0} : '0;
      cop_lvl   <= lvl[1];
    end
  end

endmodule

// File: rtl/wcfg_router_chk.sv
module wcfg_router_chk #(
  parameter int OFS_W = 8,
  parameter int LO_WIN = 1,
  localparam int NVEC = 1 << (OFS_W - 1),
  localparam int WIN_W = OFS_W - 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NVEC-1:0]   irq_req,
  input logic [3:0]        reg_sel,
  input logic              reg_re,
  input logic [7:0]        reg_rdata,
  input logic [WIN_W-1:0]  cur_win,
  input logic              cpu_valid,
  input logic [OFS_W-1:0]  cpu_vec,
  input logic [2:0]        cpu_lvl,
  input logic              cop_valid,
  input logic [2:0]        cop_lvl
);

  localparam logic [WIN_W-1:0] TOP_W = '1;
  localparam logic [WIN_W-1:0] LO_W  = WIN_W'(LO_WIN);
  localparam logic [OFS_W-1:0] SPUR_OFS = OFS_W'(LO_WIN * 16);

  // R11
  cpu_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |-> (cpu_vec == SPUR_OFS && cpu_lvl == 3'd0));

  // R2
  cpu_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |-> cpu_lvl != 3'd0);

  // R2
  cop_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    cop_valid |-> cop_lvl != 3'd0);

  // R12
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req == '0) |=> (!cpu_valid && !cop_valid));

  // R9
  spur_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_sel == 4'd0 && cur_win == LO_W) |=> reg_rdata == 8'h07);

  // R5
  irq_route_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_sel == 4'd1 && cur_win == TOP_W) |=> !reg_rdata[7]);

  // R6
  addr_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_sel == 4'd8) |=> reg_rdata[3:0] == 4'd0);

endmodule

bind wcfg_router wcfg_router_chk #(.OFS_W(OFS_W), .LO_WIN(LO_WIN)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .reg_sel(reg_sel), .reg_re(reg_re),
  .reg_rdata(reg_rdata), .cur_win(cur_win), .cpu_valid(cpu_valid), .cpu_vec(cpu_vec),
  .cpu_lvl(cpu_lvl), .cop_valid(cop_valid), .cop_lvl(cop_lvl)
);

// File: tb/wcfg_router_test.sv
module wcfg_router_test;
  localparam int CLK_P = 10;
  localparam int OFS_W = 6;
  localparam int LO_WIN = 1;
  localparam int NV = 32;
  localparam int TOPW = 3;
  localparam logic [31:0] USED = 32'hFFEF_FFFF;
  localparam int SPUR = 16;

  logic clk = 0, rst = 1;
  logic [NV-1:0] irq_req = '0;
  logic [3:0] reg_sel = '0;
  logic reg_we = 0, reg_re = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cpu_valid, cop_valid;
  logic [OFS_W-1:0] cpu_vec, cop_vec;
  logic [2:0] cpu_lvl, cop_lvl;

  int total = 0, bad = 0;
  string cur_tag = "R1";

  int m_lvl[NV];
  int m_rt[NV];
  int m_win;
  int e_cv, e_cvec, e_cl, e_ov, e_ovec, e_ol, e_rd;

  wcfg_router #(.OFS_W(OFS_W), .LO_WIN(LO_WIN), .USED_MASK(USED)) uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_valid(cpu_valid), .cpu_vec(cpu_vec), .cpu_lvl(cpu_lvl),
    .cop_valid(cop_valid), .cop_vec(cop_vec), .cop_lvl(cop_lvl));

  always #(CLK_P/2) clk = ~clk;

  function automatic bit m_cfg(int v);
    int w = v / 8;
    int s = v % 8;
    if (!USED[v] || w < LO_WIN) return 0;
    if (w == LO_WIN && s <= 4) return 0;
    if (w == TOPW && s >= 2) return 0;
    return 1;
  endfunction

  function automatic int m_read(int s);
    int v;
    if (s == 8) return m_win * 16;
    if (s > 8) return 0;
    v = m_win * 8 + s;
    if (v == LO_WIN * 8) return 7;
    return m_rt[v] * 128 + m_lvl[v];
  endfunction

  task automatic m_arb(int d, output int valid, output int vec, output int lv);
    valid = 0; vec = (d == 0) ? SPUR : 0; lv = 0;
    for (int v = NV - 1; v >= 0; v--)
      if (irq_req[v] && m_lvl[v] != 0 && m_rt[v] == d && m_lvl[v] > lv) begin
        valid = 1; vec = 2 * v; lv = m_lvl[v];
      end
  endtask

  task automatic cmp(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    if (rst) begin
      m_win = 0;
      for (int v = 0; v < NV; v++) begin m_lvl[v] = m_cfg(v) ? 1 : 0; m_rt[v] = 0; end
      e_cv = 0; e_cvec = SPUR; e_cl = 0; e_ov = 0; e_ovec = 0; e_ol = 0; e_rd = 0;
    end else begin
      m_arb(0, e_cv, e_cvec, e_cl);
      m_arb(1, e_ov, e_ovec, e_ol);
      if (reg_re) e_rd = m_read(reg_sel);
      if (reg_we) begin
        if (reg_sel == 8) m_win = reg_wdata[OFS_W-1:4];
        else if (reg_sel < 8) begin
          int v = m_win * 8 + reg_sel;
          if (m_cfg(v)) begin
            m_lvl[v] = reg_wdata[2:0];
            m_rt[v] = (v == TOPW * 8 + 1) ? 0 : reg_wdata[7];
          end
        end
      end
    end
    @(posedge clk); #2;
    cmp({cur_tag, " cpu_valid"}, cpu_valid, e_cv);
    cmp({cur_tag, " cpu_vec"}, cpu_vec, e_cvec);
    cmp({cur_tag, " cpu_lvl"}, cpu_lvl, e_cl);
    cmp({cur_tag, " cop_valid"}, cop_valid, e_ov);
    cmp({cur_tag, " cop_vec"}, cop_vec, e_ovec);
    cmp({cur_tag, " cop_lvl"}, cop_lvl, e_ol);
    cmp({cur_tag, " rdata"}, reg_rdata, e_rd);
  endtask

  task automatic wr(int s, int d);
    reg_sel = 4'(s); reg_wdata = 8'(d); reg_we = 1; tick(); reg_we = 0;
  endtask

  task automatic rd(string tag, int s, int expv);
    cur_tag = tag; reg_sel = 4'(s); reg_re = 1; tick(); reg_re = 0;
    cmp({tag, " read"}, reg_rdata, expv);
  endtask

  task automatic req(string tag, logic [NV-1:0] r, int cv, int cvec, int cl, int ov, int ovec);
    cur_tag = tag; irq_req = r; tick(); irq_req = '0;
    cmp({tag, " arb cpu_valid"}, cpu_valid, cv);
    cmp({tag, " arb cpu_vec"}, cpu_vec, cvec);
    cmp({tag, " arb cpu_lvl"}, cpu_lvl, cl);
    cmp({tag, " arb cop_valid"}, cop_valid, ov);
    cmp({tag, " arb cop_vec"}, cop_vec, ovec);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    rst = 1; tick(); tick(); rst = 0;
    req("R11", '0, 0, 'h10, 0, 0, 0);
    rd("R1", 8, 'h00);
    wr(8, 'h2F);
    rd("R6", 8, 'h20);
    rd("R1", 0, 'h01);
    rd("R10", 4, 'h00);
    req("R3", (1 << 16) | (1 << 18), 1, 'h24, 1, 0, 0);
    wr(1, 'h05); wr(2, 'h03);
    req("R2", (1 << 16) | (1 << 17) | (1 << 18), 1, 'h22, 5, 0, 0);
    wr(1, 'h00);
    req("R2", 1 << 17, 0, 'h10, 0, 0, 0);
    wr(3, 'hFF);
    rd("R7", 3, 'h87);
    req("R4", 1 << 19, 0, 'h10, 0, 1, 'h26);
    req("R4", (1 << 19) | (1 << 16), 1, 'h20, 1, 1, 'h26);
    wr(4, 'h07);
    rd("R10", 4, 'h00);
    req("R10", 1 << 20, 0, 'h10, 0, 0, 0);
    // R12: read data holds without a read strobe
    cur_tag = "R12"; reg_sel = 4'd0; tick();
    cmp("R12 rdata hold", reg_rdata, 'h00);
    wr(8, 'h30);
    wr(1, 'h86);
    rd("R5", 1, 'h06);
    req("R5", 1 << 25, 1, 'h32, 6, 0, 0);
    wr(3, 'h07);
    rd("R8", 3, 'h00);
    rd("R8", 7, 'h00);
    wr(0, 'h02);
    req("R2", (1 << 24) | (1 << 25), 1, 'h32, 6, 0, 0);
    wr(0, 'h07);
    req("R2", (1 << 24) | (1 << 25), 1, 'h30, 7, 0, 0);
    wr(8, 'h10);
    wr(0, 'h85);
    rd("R9", 0, 'h07);
    wr(2, 'h03);
    rd("R9", 2, 'h00);
    rd("R1", 5, 'h01);
    req("R9", 1 << 8, 0, 'h10, 0, 0, 0);
    wr(8, 'h00);
    wr(3, 'h07);
    rd("R10", 3, 'h00);
    req("R10", 1 << 3, 0, 'h10, 0, 0, 0);
    req("R3", (1 << 13) | (1 << 16), 1, 'h20, 1, 0, 0);
    cur_tag = "R1";
    rst = 1; tick(); tick(); rst = 0;
    rd("R1", 8, 'h00);
    wr(8, 'h20);
    rd("R1", 3, 'h01);
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule